// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block sequences one successive-approximation conversion engine with a 10-bit result. A free-running prescaler divides the peripheral clock into a reference tick. Each conversion is counted in reference periods. It starts with a sample-and-hold window of programmable length. Ten bit trials follow, most significant bit first. Two transfer periods then close the conversion. At the close, the finished code is copied whole into a result buffer and an interrupt request fires.

The analog comparator and the trial DAC sit outside the block. The block drives the trial code on `dacCode`. During each bit trial it reads back a single comparator bit, `cmpIn`, which is high when the input voltage is at or above the trial code. A start request sets the enable flag, and a stop request clears it. Single-shot mode runs one conversion and then clears the flag in hardware. Continuous mode begins a new sample window in the same cycle that the result is written.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, `enFlag`, `sampling` and `intReq` are 0 and `result` is 0.
- R2: The first sample window starts on a reference tick after `enFlag` rises. `sampling` is first seen high between 2 and div+1 clock cycles after the cycle in which `startReq` is driven.
- R3: The sample window lasts 2*(sampSel+1) reference periods, and `sampling` is high for exactly that many periods.
- R4: The reference period is div = 2 << divSel peripheral clocks (2, 4, 8 or 16). A conversion spans (12 + sample count) * div clocks, measured from the rise of `sampling` to the rise of `intReq`.
- R5: Bits are decided MSB first. In the first bit period `dacCode` is 10'h200. With `cmpIn` = (dacCode <= vin), the written result equals vin.
- R6: At the end of a conversion, all 10 bits of `result` are updated at once. `intReq` is high for exactly one clock, aligned with that update. `result` never changes at any other time.
- R7: In single-shot mode (`contMode`=0), exactly one conversion runs, and `enFlag` is 0 by the cycle in which `intReq` is high.
- R8: In continuous mode, `sampling` rises in the same cycle as `intReq`. Conversions repeat back to back, and `enFlag` stays 1.
- R9: `stopReq` aborts a running conversion. No result is written, no `intReq` is raised, and `enFlag` and `sampling` are 0 the next cycle. When `stopReq` and `startReq` are high in the same cycle, stop wins.
- R10: Changes to `divSel` and `sampSel` during a conversion apply only from the next conversion start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Sets the enable flag |
| stopReq | input | 1 | Clears the enable flag and aborts; overrides startReq |
| contMode | input | 1 | 1 = continuous, 0 = single-shot |
| divSel | input | 2 | Reference divider code, div = 2 << divSel |
| sampSel | input | 2 | Sample window code, 2*(sampSel+1) reference periods |
| cmpIn | input | 1 | Comparator: 1 when input is at or above dacCode |
| dacCode | output | 10 | Trial code for the DAC |
| sampling | output | 1 | Sample-and-hold window active |
| result | output | 10 | Result buffer |
| intReq | output | 1 | One-clock conversion-complete request |
| enFlag | output | 1 | Enable flag |

## Verification
In continuous mode, the result write that ends one conversion and the load that starts the next happen on the same clock edge. That edge also latches any new divider and sample settings. The bench changes both settings during a running conversion, which makes that edge carry a commit of old-setting data together with a start under new settings. It then checks three things: the result matches the analog value of the finished conversion, the finished conversion still timed with the old settings, and the following conversion timed with the new ones.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int SAR_BITS = 10;
  localparam int IDX_W = $clog2(SAR_BITS);

  typedef struct packed {
    logic load;
    logic decide;
    logic commit;
    logic bitActive;
    logic [IDX_W-1:0] bitIdx;
  } seqStrobe_t;
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int DIV_SEL_W = 2,
  parameter int SAMP_SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startReq,
  input  logic                  stopReq,
  input  logic                  contMode,
  input  logic [DIV_SEL_W-1:0]  divSel,
  input  logic [SAMP_SEL_W-1:0] sampSel,
  output seqStrobe_t            strobe,
  output logic                  sampling,
  output logic                  enFlag
);
  localparam int MAX_DIV = 2 << ((1 << DIV_SEL_W) - 1);
  localparam int PRE_W = $clog2(MAX_DIV);
  localparam int MAX_SAMP = 2 << SAMP_SEL_W;
  localparam int STEP_W = $clog2(SAR_BITS + 2 + MAX_SAMP + 1);

  logic                  busy;
  logic [STEP_W-1:0]     step;
  logic [DIV_SEL_W-1:0]  divLat;
  logic [SAMP_SEL_W-1:0] sampLat;
  logic [PRE_W-1:0]      preCnt;
  logic [PRE_W:0]        divLen;
  logic [STEP_W-1:0]     sampLen, totLen;
  logic refTick, startNow, finish, restart, bitPhase;

  // divider in force: live while idle, latched while converting
  assign divLen = (PRE_W + 1)'(2) << (busy ? divLat : divSel);
  assign refTick = ({1'b0, preCnt} >= divLen - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else if (refTick) preCnt <= '0;
    else preCnt <= preCnt + 1'b1;
  end

  assign sampLen = (STEP_W'(sampLat) + 1'b1) << 1;
  assign totLen = sampLen + STEP_W'(SAR_BITS + 2);
  assign startNow = !busy && refTick && enFlag && !stopReq;
  assign finish = busy && refTick && (step == totLen - 1'b1) && !stopReq;
  assign restart = finish && contMode;
  assign bitPhase = busy && (step >= sampLen) && (step < sampLen + STEP_W'(SAR_BITS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      step <= '0;
      divLat <= '0;
      sampLat <= '0;
      enFlag <= 1'b0;
    end else begin
      if (stopReq) busy <= 1'b0;
      else if (startNow || restart) begin
        busy <= 1'b1;
        step <= '0;
        divLat <= divSel;
        sampLat <= sampSel;
      end else if (finish) busy <= 1'b0;
      else if (busy && refTick) step <= step + 1'b1;

      if (stopReq) enFlag <= 1'b0;
      else if (startReq) enFlag <= 1'b1;
      else if (finish && !contMode) enFlag <= 1'b0;
    end
  end

  assign sampling = busy && (step < sampLen);

  always_comb begin
    strobe.load = startNow || restart;
    strobe.decide = bitPhase && refTick && !stopReq;
    strobe.commit = finish;
    strobe.bitActive = bitPhase;
    strobe.bitIdx = IDX_W'(STEP_W'(SAR_BITS - 1) - (step - sampLen));
  end
endmodule

// File: rtl/sar_seq_dp.sv
module sar_seq_dp
  import sar_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic                cmpIn,
  output logic [SAR_BITS-1:0] dacCode,
  output logic [SAR_BITS-1:0] result,
  output logic                intReq
);
  logic [SAR_BITS-1:0] trial;
  logic [SAR_BITS-1:0] trialBit;

  assign trialBit = strobe.bitActive ? (SAR_BITS'(1) << strobe.bitIdx) : '0;
  assign dacCode = trial | trialBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trial <= '0;
      result <= '0;
      intReq <= 1'b0;
    end else begin
      if (strobe.load) trial <= '0;
      else if (strobe.decide) trial[strobe.bitIdx] <= cmpIn;
      if (strobe.commit) result <= trial;
      intReq <= strobe.commit;
    end
  end
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
#(
  parameter int DIV_SEL_W = 2,
  parameter int SAMP_SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startReq,
  input  logic                  stopReq,
  input  logic                  contMode,
  input  logic [DIV_SEL_W-1:0]  divSel,
  input  logic [SAMP_SEL_W-1:0] sampSel,
  input  logic                  cmpIn,
  output logic [SAR_BITS-1:0]   dacCode,
  output logic                  sampling,
  output logic [SAR_BITS-1:0]   result,
  output logic                  intReq,
  output logic                  enFlag
);
  seqStrobe_t strobe;

  sar_seq_ctrl #(.DIV_SEL_W(DIV_SEL_W), .SAMP_SEL_W(SAMP_SEL_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .contMode(contMode), .divSel(divSel), .sampSel(sampSel),
    .strobe(strobe), .sampling(sampling), .enFlag(enFlag)
  );

  sar_seq_dp i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpIn(cmpIn),
    .dacCode(dacCode), .result(result), .intReq(intReq)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk
  import sar_seq_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                startReq,
  input logic                stopReq,
  input logic                contMode,
  input logic                sampling,
  input logic                intReq,
  input logic                enFlag,
  input logic [SAR_BITS-1:0] result
);
  a_r6_int_one_pulse: assert property (@(posedge clk) disable iff (!rstN)
    intReq |=> !intReq);

  a_r6_result_only_on_int: assert property (@(posedge clk) disable iff (!rstN)
    !intReq |-> $stable(result));

  a_r7_oneshot_clears_en: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && !$past(contMode) && !$past(startReq)) |-> !enFlag);

  a_r8_cont_restarts: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && $past(contMode)) |-> (sampling && enFlag));

  a_r9_stop_halts: assert property (@(posedge clk) disable iff (!rstN)
    $past(stopReq) |-> (!enFlag && !sampling && !intReq));

  a_r2_idle_no_sample: assert property (@(posedge clk) disable iff (!rstN)
    !enFlag |-> !sampling);
endmodule

bind sar_seq_top sar_seq_chk i_chk (.*);

// File: tb/test_sar_seq_top.sv
module test_sar_seq_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, stopReq = 1'b0, contMode = 1'b0;
  logic [1:0] divSel = '0, sampSel = '0;
  logic cmpIn;
  logic [9:0] dacCode, result;
  logic sampling, intReq, enFlag;
  logic [9:0] vin = '0;
  int cyc = 0;
  int nChecks = 0, nFails = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign cmpIn = (dacCode <= vin);

  sar_seq_top i_sar_seq_top (.*);

  function automatic int divOf(input int d); return 2 << d; endfunction
  function automatic int sampOf(input int s); return 2 * (s + 1); endfunction
  function automatic int convClks(input int d, input int s);
    return (12 + sampOf(s)) * divOf(d);
  endfunction

  task automatic check(input string req, input bit ok, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  task automatic waitFor(input bit sigSel);
    // sigSel 0 -> sampling high, 1 -> intReq high
    while (!(sigSel ? intReq : sampling)) @(negedge clk);
  endtask

  task automatic oneShot(input int d, input int s, input int v);
    int n, tS, tE, tI;
    @(negedge clk);
    divSel = 2'(d); sampSel = 2'(s); vin = 10'(v); contMode = 1'b0; startReq = 1'b1;
    n = cyc;
    @(negedge clk);
    startReq = 1'b0;
    waitFor(1'b0);
    tS = cyc;
    check("R2 start latency", (tS - n >= 2) && (tS - n <= divOf(d) + 1), tS - n, divOf(d) + 1);
    while (sampling) @(negedge clk);
    tE = cyc;
    check("R3 sample length", tE - tS == sampOf(s) * divOf(d), tE - tS, sampOf(s) * divOf(d));
    check("R5 first trial MSB", dacCode == 10'h200, dacCode, 10'h200);
    waitFor(1'b1);
    tI = cyc;
    check("R4 conversion clocks", tI - tS == convClks(d, s), tI - tS, convClks(d, s));
    check("R5 result value", result == 10'(v), result, v);
    check("R7 en cleared", enFlag == 1'b0, enFlag, 0);
    @(negedge clk);
    check("R6 int single pulse", intReq == 1'b0, intReq, 0);
    begin
      bit extra = 1'b0;
      repeat (40) begin
        @(negedge clk);
        if (sampling || intReq) extra = 1'b1;
      end
      check("R7 no further conversion", !extra, extra, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check("watchdog", 1'b0, cyc, 0);
    summary();
  end

  initial begin
    int t1, t2, t3;
    logic [9:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset en", enFlag == 1'b0, enFlag, 0);
    check("R1 reset int/sampling", !intReq && !sampling, {intReq, sampling}, 0);
    check("R1 reset result", result == '0, result, 0);
    rstN = 1'b1;

    // directed corners: extremes of code and divider
    oneShot(2, 0, 112 % 1024);
    oneShot(0, 3, 0);
    oneShot(3, 1, 1023);
    oneShot(0, 0, 10'h155);
    // random single-shot conversions
    for (int i = 0; i < 10; i++)
      oneShot($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 1023));

    // continuous mode with settings changed mid-conversion (R8, R10)
    @(negedge clk);
    divSel = 2'd1; sampSel = 2'd0; vin = 10'd700; contMode = 1'b1; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitFor(1'b0);
    @(negedge clk);
    divSel = 2'd0; sampSel = 2'd3;   // changed mid-conversion
    waitFor(1'b1);
    t1 = cyc;
    check("R8 result conv1", result == 10'd700, result, 700);
    check("R8 restart with write", sampling && enFlag, {sampling, enFlag}, 3);
    vin = 10'd33;
    @(negedge clk);
    waitFor(1'b1);
    t2 = cyc;
    check("R10 new settings period", t2 - t1 == convClks(0, 3), t2 - t1, convClks(0, 3));
    check("R8 result conv2", result == 10'd33, result, 33);
    vin = 10'd999;
    divSel = 2'd2; sampSel = 2'd1;
    @(negedge clk);
    waitFor(1'b1);
    t3 = cyc;
    check("R10 old settings held", t3 - t2 == convClks(0, 3), t3 - t2, convClks(0, 3));
    check("R8 result conv3", result == 10'd999, result, 999);
    check("R8 en stays", enFlag == 1'b1, enFlag, 1);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    check("R9 stop clears", !enFlag && !sampling, {enFlag, sampling}, 0);
    contMode = 1'b0;

    // abort mid-conversion (R9)
    held = result;
    @(negedge clk);
    divSel = 2'd2; sampSel = 2'd0; vin = 10'd77; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitFor(1'b0);
    repeat (30) @(negedge clk);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    check("R9 abort state", !enFlag && !sampling, {enFlag, sampling}, 0);
    begin
      bit sawInt = 1'b0;
      repeat (200) begin
        @(negedge clk);
        if (intReq || sampling) sawInt = 1'b1;
      end
      check("R9 no write after abort", !sawInt, sawInt, 0);
    end
    check("R9 result kept", result == held, result, held);

    // stop and start together while idle: stop wins
    stopReq = 1'b1; startReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0; startReq = 1'b0;
    begin
      bit act = enFlag;
      repeat (40) begin
        @(negedge clk);
        if (sampling || enFlag) act = 1'b1;
      end
      check("R9 stop priority", !act, act, 0);
    end
    summary();
  end
endmodule